// File: doc/BRIEF.md
# Opcode Class and Length Decoder

This block sits at the front of an instruction pipeline that executes 16-bit opcode words. It takes instruction words one at a time from a valid/ready word stream. It treats the first word it accepts as an opcode and decides which class the instruction belongs to. It also decides how many further words belong to the same instruction: immediate data, branch displacements, and the extension words of the source and destination operands. The block then accepts exactly that many further words. Where a following word carries a displacement or an immediate value, the block keeps that value.

When the last word of an instruction has been accepted, the block raises a one-cycle completion pulse. Alongside it, it presents these results:
- the class code;
- the operand size;
- the condition code;
- the two raw register fields;
- a quick immediate;
- a 32-bit displacement or data value;
- the total length in words;
- an illegal flag.

An internal program counter advances by 2 for every word accepted. A load input can overwrite it, for example after a taken jump. The block decodes only. It neither executes instructions nor evaluates condition flags.

Top module: `opc_len_decoder`

## Requirements
- R1: While reset is held, and up to the first clock after reset is released, the ready output, the completion pulse and the program counter are all 0.
- R2: Opcode bits 15..12 equal to 1, 3 or 2 give class MOVE (code 1), with size code 00, 01 or 10 respectively. For the word and long forms (bits 15..12 = 3 or 2), a destination mode (bits 8..6) of 1 gives class MOVEA (code 2) instead.
- R3: The length equals 1, plus any immediate or displacement words, plus the extension words of each operand, counted source first and then destination.
  - Source operand fields: mode bits 5..3, register bits 2..0. Destination operand fields: register bits 11..9, mode bits 8..6.
  - Extension words by mode: modes 0 to 4 need 0 words; modes 5 and 6 need 1 word.
  - Mode 7 by register value: register 0 needs 1 word, register 1 needs 2, register 2 needs 1, register 3 needs 1. Register 4 needs 2 words at long size and 1 word otherwise.
- R4: Group 5 with size bits 7..6 not equal to 11 gives ADDQ (code 3), or SUBQ (code 4) when bit 8 is set. The quick value is bits 11..9, where 0 reads as 8.
- R5: Group 5 with size 11 reports the condition from bits 11..8. With mode 1 it is DBCC (code 6, size 01), and one following word gives the sign-extended displacement. Otherwise it is SCC (code 5, size 00), and its operand is counted at byte size.
- R6: Group 6 takes the low byte, sign-extended, as the displacement.
  - A low byte of 0x00 means one following word gives the sign-extended displacement.
  - A low byte of 0xFF, when the extended-mode input is 1, means two following words give the displacement, high word first.
  - A low byte of 0xFF with the extended-mode input at 0 is a one-word branch with displacement -1.
- R7: In group 6, condition 0 gives BRA (code 7) and condition 1 gives BSR (code 8). Every other condition gives BCC (code 9). The size code is 11.
- R8: Group 7 gives MOVEQ (code 10, size 10), with the quick value equal to the low byte. If bit 8 is set, the instruction is illegal.
- R9: Group 14 with size bits not equal to 11 is a register shift at that size. With bit 5 clear it is SHIFT_IMM (code 11), and the quick value is bits 11..9 with 0 reading as 8. With bit 5 set it is SHIFT_REG (code 12), with quick value 0. Size 11 gives SHIFT_MEM (code 13): size 01, quick value 1, and an operand counted at word size.
- R10: Group 0 with low six bits 111100 and size 00 gives CCR_IMM (code 14, size 00). Size 01 gives SR_IMM (code 15, size 01). Either form has one data word, zero-extended into the displacement output. Bits 11..8 must be 0, 2 or 10; anything else, or a size of 1x, is illegal.
- R11: An illegal instruction reports the illegal flag, class 0, size 11, quick 0 and displacement 0, with length 1, and consumes no further words. The following are illegal:
  - groups 10 and 15;
  - any decoded operand with mode 7 and register 5, 6 or 7.
- R12: The program counter increases by 2 for each accepted word. A load without an accepted word sets it to the load value. A load in the same cycle as an accepted word sets it to the load value plus 2.
- R13: The completion pulse rises in the cycle after the final word of an instruction is accepted, and lasts one cycle unless another instruction completes in the next cycle. Results do not change in any cycle that accepts no word. Gaps in the stream only delay completion.
- R14: Groups 4, 8, 9, 11, 12, 13, and group 0 outside R10, give class OTHER (code 0) with length 1. Their size code is taken raw from bits 7..6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ext_mode_i | input | 1 | Enables 32-bit branch displacements |
| pc_load_i | input | 1 | Overwrite the program counter |
| pc_load_val_i | input | ADDR_W | Value loaded into the program counter |
| wd_valid_i | input | 1 | Stream word present |
| wd_data_i | input | 16 | Stream word |
| wd_ready_o | output | 1 | Block accepts a word this cycle |
| dec_done_o | output | 1 | One-cycle completion pulse |
| cls_o | output | 4 | Class code |
| size_o | output | 2 | Size code (11 = none) |
| cond_o | output | 4 | Condition field |
| reg_hi_o | output | 3 | Opcode bits 11..9 |
| reg_lo_o | output | 3 | Opcode bits 2..0 |
| quick_o | output | 8 | Quick immediate or shift count |
| disp_o | output | 32 | Displacement or data value |
| len_o | output | 3 | Instruction length in words |
| illegal_o | output | 1 | Instruction is illegal |
| pc_o | output | ADDR_W | Program counter |

## Verification
A program-counter load and the acceptance of a stream word can fall in the same cycle. The load must win, and the accepted word must still be counted from the loaded address. The bench provokes this by raising the load on the very clock that takes the first word of a three-word branch. It then requires the counter sampled with that branch's completion pulse to read the load value plus 6. A separate load with no word present is checked to land exactly on the load value.

// File: rtl/opl_pkg.sv
package opl_pkg;

    localparam int OPL_WORD_W  = 16;
    localparam int OPL_DISP_W  = 32;
    localparam int OPL_MAX_LEN = 5;
    localparam int OPL_LEN_W   = $clog2(OPL_MAX_LEN + 1);
    localparam int OPL_EXT_W   = $clog2(OPL_MAX_LEN);

    typedef enum logic [3:0] {
        CL_OTHER     = 4'd0,
        CL_MOVE      = 4'd1,
        CL_MOVEA     = 4'd2,
        CL_ADDQ      = 4'd3,
        CL_SUBQ      = 4'd4,
        CL_SCC       = 4'd5,
        CL_DBCC      = 4'd6,
        CL_BRA       = 4'd7,
        CL_BSR       = 4'd8,
        CL_BCC       = 4'd9,
        CL_MOVEQ     = 4'd10,
        CL_SHIFT_IMM = 4'd11,
        CL_SHIFT_REG = 4'd12,
        CL_SHIFT_MEM = 4'd13,
        CL_CCR_IMM   = 4'd14,
        CL_SR_IMM    = 4'd15
    } opl_class_e;

    typedef enum logic [1:0] {
        SZ_B    = 2'b00,
        SZ_W    = 2'b01,
        SZ_L    = 2'b10,
        SZ_NONE = 2'b11
    } opl_size_e;

    // how the following words feed the displacement output
    typedef enum logic [1:0] {
        CAP_NONE   = 2'd0,
        CAP_SEXT_W = 2'd1,
        CAP_LONG   = 2'd2,
        CAP_ZEXT_W = 2'd3
    } opl_cap_e;

    typedef struct packed {
        opl_class_e              cls;
        opl_size_e               size;
        logic [3:0]              cond;
        logic [7:0]              quick;
        logic [OPL_DISP_W-1:0]   disp;
        logic [OPL_EXT_W-1:0]    n_ext;
        opl_cap_e                cap;
        logic                    illegal;
    } opl_dec_t;

endpackage

// File: rtl/opl_ea_words.sv
module opl_ea_words
    import opl_pkg::*;
(
    input  logic [2:0] mode,
    input  logic [2:0] rn,
    input  opl_size_e  sz,
    output logic [1:0] words,
    output logic       bad
);
    always_comb begin
        words = 2'd0;
        bad   = 1'b0;
        unique case (mode)
            3'd5, 3'd6: words = 2'd1;
            3'd7: begin
                unique case (rn)
                    3'd0, 3'd2, 3'd3: words = 2'd1;
                    3'd1:             words = 2'd2;
                    3'd4:             words = (sz == SZ_L) ? 2'd2 : 2'd1;
                    default:          bad   = 1'b1;
                endcase
            end
            default: words = 2'd0;
        endcase
    end
endmodule

// File: rtl/opl_classify.sv
module opl_classify
    import opl_pkg::*;
(
    input  logic [OPL_WORD_W-1:0] op,
    input  logic                  ext_mode,
    output opl_dec_t              dec
);
    localparam int N_OPND = 2;   // 0 = source fields, 1 = destination fields

    logic [3:0] grp;
    logic [1:0] szf;
    logic [2:0] qf;
    assign grp = op[15:12];
    assign szf = op[7:6];
    assign qf  = op[11:9];

    logic [2:0] ea_mode [N_OPND];
    logic [2:0] ea_rn   [N_OPND];
    logic [1:0] ea_w    [N_OPND];
    logic       ea_bad  [N_OPND];
    opl_size_e  ea_sz;

    assign ea_mode[0] = op[5:3];
    assign ea_rn[0]   = op[2:0];
    assign ea_mode[1] = op[8:6];
    assign ea_rn[1]   = op[11:9];

    // operand size used for immediate-length decisions
    always_comb begin
        unique case (grp)
            4'h1:    ea_sz = SZ_B;
            4'h2:    ea_sz = SZ_L;
            4'h3:    ea_sz = SZ_W;
            4'h5:    ea_sz = (szf == 2'b11) ? SZ_B : opl_size_e'(szf);
            default: ea_sz = SZ_W;
        endcase
    end

    genvar g;
    generate
        for (g = 0; g < N_OPND; g++) begin : g_opnd
            opl_ea_words u_ea (
                .mode  (ea_mode[g]),
                .rn    (ea_rn[g]),
                .sz    (ea_sz),
                .words (ea_w[g]),
                .bad   (ea_bad[g])
            );
        end
    endgenerate

    logic                 use_src_d, use_dst_d;
    logic [OPL_EXT_W-1:0] n_imm_d;
    logic [7:0]           q_eight;
    assign q_eight = (qf == 3'd0) ? 8'd8 : {5'd0, qf};

    always_comb begin
        dec         = '0;
        dec.cls     = CL_OTHER;
        dec.size    = SZ_NONE;
        dec.cap     = CAP_NONE;
        use_src_d   = 1'b0;
        use_dst_d   = 1'b0;
        n_imm_d     = '0;

        unique case (grp)
            4'h1, 4'h2, 4'h3: begin
                dec.size  = ea_sz;
                dec.cls   = (ea_mode[1] == 3'd1 && grp != 4'h1) ? CL_MOVEA : CL_MOVE;
                use_src_d = 1'b1;
                use_dst_d = 1'b1;
            end
            4'h5: begin
                if (szf != 2'b11) begin
                    dec.cls   = op[8] ? CL_SUBQ : CL_ADDQ;
                    dec.size  = opl_size_e'(szf);
                    dec.quick = q_eight;
                    use_src_d = 1'b1;
                end else begin
                    dec.cond = op[11:8];
                    if (ea_mode[0] == 3'd1) begin
                        dec.cls  = CL_DBCC;
                        dec.size = SZ_W;
                        n_imm_d  = OPL_EXT_W'(1);
                        dec.cap  = CAP_SEXT_W;
                    end else begin
                        dec.cls   = CL_SCC;
                        dec.size  = SZ_B;
                        use_src_d = 1'b1;
                    end
                end
            end
            4'h6: begin
                dec.cond = op[11:8];
                dec.disp = {{(OPL_DISP_W-8){op[7]}}, op[7:0]};
                unique case (op[11:8])
                    4'h0:    dec.cls = CL_BRA;
                    4'h1:    dec.cls = CL_BSR;
                    default: dec.cls = CL_BCC;
                endcase
                if (op[7:0] == 8'h00) begin
                    n_imm_d = OPL_EXT_W'(1);
                    dec.cap = CAP_SEXT_W;
                end else if (op[7:0] == 8'hFF && ext_mode) begin
                    n_imm_d = OPL_EXT_W'(2);
                    dec.cap = CAP_LONG;
                end
            end
            4'h7: begin
                if (op[8]) begin
                    dec.illegal = 1'b1;
                end else begin
                    dec.cls   = CL_MOVEQ;
                    dec.size  = SZ_L;
                    dec.quick = op[7:0];
                end
            end
            4'hE: begin
                if (szf != 2'b11) begin
                    dec.size = opl_size_e'(szf);
                    if (op[5]) begin
                        dec.cls = CL_SHIFT_REG;
                    end else begin
                        dec.cls   = CL_SHIFT_IMM;
                        dec.quick = q_eight;
                    end
                end else begin
                    dec.cls   = CL_SHIFT_MEM;
                    dec.size  = SZ_W;
                    dec.quick = 8'd1;
                    use_src_d = 1'b1;
                end
            end
            4'h0: begin
                if (op[5:0] == 6'b111100) begin
                    if (op[7] || !(op[11:8] == 4'h0 || op[11:8] == 4'h2 || op[11:8] == 4'hA)) begin
                        dec.illegal = 1'b1;
                    end else begin
                        dec.cls  = op[6] ? CL_SR_IMM : CL_CCR_IMM;
                        dec.size = op[6] ? SZ_W : SZ_B;
                        n_imm_d  = OPL_EXT_W'(1);
                        dec.cap  = CAP_ZEXT_W;
                    end
                end else begin
                    dec.size = opl_size_e'(szf);
                end
            end
            4'hA, 4'hF: dec.illegal = 1'b1;
            default:    dec.size = opl_size_e'(szf);
        endcase

        if ((use_src_d && ea_bad[0]) || (use_dst_d && ea_bad[1]))
            dec.illegal = 1'b1;

        dec.n_ext = n_imm_d
                  + (use_src_d ? OPL_EXT_W'(ea_w[0]) : '0)
                  + (use_dst_d ? OPL_EXT_W'(ea_w[1]) : '0);

        if (dec.illegal) begin
            dec.cls   = CL_OTHER;
            dec.size  = SZ_NONE;
            dec.cond  = '0;
            dec.quick = '0;
            dec.disp  = '0;
            dec.n_ext = '0;
            dec.cap   = CAP_NONE;
        end
    end
endmodule

// File: rtl/opc_len_decoder.sv
module opc_len_decoder
    import opl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  ext_mode_i,
    input  logic                  pc_load_i,
    input  logic [ADDR_W-1:0]     pc_load_val_i,
    input  logic                  wd_valid_i,
    input  logic [15:0]           wd_data_i,
    output logic                  wd_ready_o,
    output logic                  dec_done_o,
    output logic [3:0]            cls_o,
    output logic [1:0]            size_o,
    output logic [3:0]            cond_o,
    output logic [2:0]            reg_hi_o,
    output logic [2:0]            reg_lo_o,
    output logic [7:0]            quick_o,
    output logic [31:0]           disp_o,
    output logic [2:0]            len_o,
    output logic                  illegal_o,
    output logic [ADDR_W-1:0]     pc_o
);
    localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(2);

    typedef struct packed {
        logic                   run;
        logic                   busy;
        logic [OPL_EXT_W-1:0]   remain;
        opl_cap_e               cap;
        logic                   cap_first;
        logic [ADDR_W-1:0]      pc;
        logic [3:0]             cls;
        logic [1:0]             size;
        logic [3:0]             cond;
        logic [2:0]             rhi;
        logic [2:0]             rlo;
        logic [7:0]             quick;
        logic [OPL_DISP_W-1:0]  disp;
        logic [OPL_LEN_W-1:0]   len;
        logic                   illegal;
        logic                   done;
    } state_t;

    state_t   st_d, st_q;
    opl_dec_t dec_w;
    logic     accept_w;

    opl_classify u_cls (
        .op       (wd_data_i),
        .ext_mode (ext_mode_i),
        .dec      (dec_w)
    );

    assign accept_w = wd_valid_i && st_q.run;

    always_comb begin
        logic [ADDR_W-1:0] pc_base;
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.run  = 1'b1;

        pc_base = pc_load_i ? pc_load_val_i : st_q.pc;
        st_d.pc = accept_w ? pc_base + PC_STEP : pc_base;

        if (accept_w) begin
            if (!st_q.busy) begin
                st_d.cls       = dec_w.cls;
                st_d.size      = dec_w.size;
                st_d.cond      = dec_w.cond;
                st_d.rhi       = wd_data_i[11:9];
                st_d.rlo       = wd_data_i[2:0];
                st_d.quick     = dec_w.quick;
                st_d.disp      = dec_w.disp;
                st_d.illegal   = dec_w.illegal;
                st_d.len       = OPL_LEN_W'(1) + OPL_LEN_W'(dec_w.n_ext);
                st_d.remain    = dec_w.n_ext;
                st_d.cap       = dec_w.cap;
                st_d.cap_first = 1'b1;
                if (dec_w.n_ext == '0) st_d.done = 1'b1;
                else                   st_d.busy = 1'b1;
            end else begin
                unique case (st_q.cap)
                    CAP_SEXT_W: st_d.disp = {{(OPL_DISP_W-16){wd_data_i[15]}}, wd_data_i};
                    CAP_ZEXT_W: st_d.disp = {{(OPL_DISP_W-16){1'b0}}, wd_data_i};
                    CAP_LONG: begin
                        if (st_q.cap_first) st_d.disp[31:16] = wd_data_i;
                        else                st_d.disp[15:0]  = wd_data_i;
                    end
                    default: ;
                endcase
                st_d.cap_first = 1'b0;
                st_d.remain    = st_q.remain - OPL_EXT_W'(1);
                if (st_q.remain == OPL_EXT_W'(1)) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.size <= SZ_NONE;
            st_q.cap  <= CAP_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign wd_ready_o = st_q.run;
    assign dec_done_o = st_q.done;
    assign cls_o      = st_q.cls;
    assign size_o     = st_q.size;
    assign cond_o     = st_q.cond;
    assign reg_hi_o   = st_q.rhi;
    assign reg_lo_o   = st_q.rlo;
    assign quick_o    = st_q.quick;
    assign disp_o     = st_q.disp;
    assign len_o      = st_q.len;
    assign illegal_o  = st_q.illegal;
    assign pc_o       = st_q.pc;
endmodule

// File: rtl/opl_checker.sv
module opl_checker
    import opl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              pc_load_i,
    input logic              wd_valid_i,
    input logic              wd_ready_o,
    input logic              dec_done_o,
    input logic [3:0]        cls_o,
    input logic [7:0]        quick_o,
    input logic [31:0]       disp_o,
    input logic [2:0]        len_o,
    input logic              illegal_o,
    input logic [ADDR_W-1:0] pc_o
);
    // R12: a plain accepted word moves the counter by exactly 2
    a_r12_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pc_load_i && wd_valid_i && wd_ready_o) |=> (pc_o == $past(pc_o) + ADDR_W'(2)));

    // R12: no load and no word leaves the counter alone
    a_r12_pc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pc_load_i && !(wd_valid_i && wd_ready_o)) |=> $stable(pc_o));

    // R13: an idle cycle changes no result and raises no completion
    a_r13_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wd_valid_i && wd_ready_o) |=> ($stable(cls_o) && $stable(disp_o) && $stable(len_o) && !dec_done_o));

    // R11: illegal results always have length 1
    a_r11_illegal_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_done_o && illegal_o) |-> (len_o == 3'd1 && cls_o == 4'd0));

    // R3: completed lengths stay in 1..max
    a_r3_len_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dec_done_o |-> (len_o >= 3'd1 && len_o <= 3'(OPL_MAX_LEN)));

    // R4: quick add/subtract values lie in 1..8
    a_r4_quick_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_done_o && (cls_o == 4'd3 || cls_o == 4'd4)) |-> (quick_o >= 8'd1 && quick_o <= 8'd8));
endmodule

bind opc_len_decoder opl_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pc_load_i  (pc_load_i),
    .wd_valid_i (wd_valid_i),
    .wd_ready_o (wd_ready_o),
    .dec_done_o (dec_done_o),
    .cls_o      (cls_o),
    .quick_o    (quick_o),
    .disp_o     (disp_o),
    .len_o      (len_o),
    .illegal_o  (illegal_o),
    .pc_o       (pc_o)
);

// File: tb/opc_len_decoder_tb.sv
module opc_len_decoder_tb;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ext_mode = 1'b0;
    logic              pc_load = 1'b0;
    logic [ADDR_W-1:0] pc_val = '0;
    logic              wd_valid = 1'b0;
    logic [15:0]       wd_data = '0;
    logic              wd_ready, done, illegal;
    logic [3:0]        cls, cond;
    logic [1:0]        size;
    logic [2:0]        rhi, rlo, len;
    logic [7:0]        quick;
    logic [31:0]       disp;
    logic [ADDR_W-1:0] pc;

    always #10 clk = ~clk;

    opc_len_decoder #(.ADDR_W(ADDR_W)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .ext_mode_i(ext_mode),
        .pc_load_i(pc_load), .pc_load_val_i(pc_val),
        .wd_valid_i(wd_valid), .wd_data_i(wd_data), .wd_ready_o(wd_ready),
        .dec_done_o(done), .cls_o(cls), .size_o(size), .cond_o(cond),
        .reg_hi_o(rhi), .reg_lo_o(rlo), .quick_o(quick), .disp_o(disp),
        .len_o(len), .illegal_o(illegal), .pc_o(pc)
    );

    typedef struct {
        logic [3:0]  cls;
        logic [1:0]  size;
        logic [3:0]  cond;
        logic [7:0]  quick;
        logic [31:0] disp;
        logic [2:0]  len;
        logic        ill;
        logic [31:0] pc;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    logic [31:0] exp_pc = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv, input string what);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // monitor: compare every completion against the scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R13 unexpected completion: actual cls %0d expected none", cls);
            end else begin
                exp_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (cls !== e.cls || size !== e.size || cond !== e.cond || quick !== e.quick ||
                    disp !== e.disp || len !== e.len || illegal !== e.ill || pc !== e.pc) begin
                    n_bad++;
                    $display("FAIL %s: actual cls=%0d sz=%0d cc=%0d q=%h d=%h len=%0d ill=%0d pc=%h expected cls=%0d sz=%0d cc=%0d q=%h d=%h len=%0d ill=%0d pc=%h",
                             t, cls, size, cond, quick, disp, len, illegal, pc,
                             e.cls, e.size, e.cond, e.quick, e.disp, e.len, e.ill, e.pc);
                end
            end
        end
    end

    // driver: push expectation, then feed the words
    task automatic issue(input string tag, input int n,
                         input logic [15:0] w0, input logic [15:0] w1, input logic [15:0] w2,
                         input logic [15:0] w3, input logic [15:0] w4,
                         input logic [3:0] ecls, input logic [1:0] esz, input logic [3:0] ecc,
                         input logic [7:0] eq, input logic [31:0] ed, input logic eill,
                         input int gap, input bit ld, input logic [31:0] ldv);
        logic [15:0] w[5];
        exp_t e;
        w[0] = w0; w[1] = w1; w[2] = w2; w[3] = w3; w[4] = w4;
        exp_pc = (ld ? ldv : exp_pc) + 32'(2 * n);
        e.cls = ecls; e.size = esz; e.cond = ecc; e.quick = eq; e.disp = ed;
        e.len = 3'(n); e.ill = eill; e.pc = exp_pc;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wd_valid = 1'b1;
            wd_data  = w[i];
            pc_load  = (i == 0) && ld;
            pc_val   = ldv;
            @(posedge clk);
            if (gap > 0 && i < n - 1) begin
                @(negedge clk);
                wd_valid = 1'b0;
                pc_load  = 1'b0;
                for (int k = 1; k < gap; k++) @(negedge clk);
            end
        end
    endtask

    task automatic idle(input int k);
        @(negedge clk);
        wd_valid = 1'b0;
        pc_load  = 1'b0;
        for (int i = 1; i < k; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", {29'd0, wd_ready, done, 1'b0}, 32'd0, "ready/done in reset");
        chk("R1", pc, 32'd0, "pc in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {31'd0, wd_ready}, 32'd1, "ready after reset");

        // R2 move classes
        issue("R2 move.w reg", 1, 16'h3401, 0,0,0,0, 4'd1, 2'b01, 4'd0, 8'd0, 32'd0, 1'b0, 0, 0, 0);
        issue("R2 movea.l d16", 2, 16'h2668, 16'h0040, 0,0,0, 4'd2, 2'b10, 4'd0, 8'd0, 32'd0, 1'b0, 2, 0, 0);
        issue("R3 move.l imm to abs.l", 5, 16'h23FC, 16'h1111, 16'h2222, 16'h3333, 16'h4444,
              4'd1, 2'b10, 4'd0, 8'd0, 32'd0, 1'b0, 0, 0, 0);
        issue("R3 move.b index to ind", 2, 16'h12B0, 16'h0003, 0,0,0, 4'd1, 2'b00, 4'd0, 8'd0, 32'd0, 1'b0, 0, 0, 0);
        // R4 quick
        issue("R4 addq zero means 8", 1, 16'h5083, 0,0,0,0, 4'd3, 2'b10, 4'd0, 8'd8, 32'd0, 1'b0, 0, 0, 0);
        issue("R4 subq abs.w", 2, 16'h5778, 16'h0100, 0,0,0, 4'd4, 2'b01, 4'd0, 8'd3, 32'd0, 1'b0, 1, 0, 0);
        // R5 dbcc / scc
        issue("R5 dbcc disp", 2, 16'h56CA, 16'hFFFC, 0,0,0, 4'd6, 2'b01, 4'd6, 8'd0, 32'hFFFFFFFC, 1'b0, 3, 0, 0);
        issue("R5 scc", 1, 16'h57C0, 0,0,0,0, 4'd5, 2'b00, 4'd7, 8'd0, 32'd0, 1'b0, 0, 0, 0);
        // R6 / R7 branches
        issue("R6 R7 bra short", 1, 16'h6080, 0,0,0,0, 4'd7, 2'b11, 4'd0, 8'd0, 32'hFFFFFF80, 1'b0, 0, 0, 0);
        issue("R6 R7 bsr word", 2, 16'h6100, 16'h0010, 0,0,0, 4'd8, 2'b11, 4'd1, 8'd0, 32'h00000010, 1'b0, 0, 0, 0);
        idle(1);
        ext_mode = 1'b1;
        issue("R6 R12 bcc long with pc load", 3, 16'h66FF, 16'h1234, 16'h5678, 0,0,
              4'd9, 2'b11, 4'd6, 8'd0, 32'h12345678, 1'b0, 1, 1, 32'h00001000);
        idle(1);
        ext_mode = 1'b0;
        issue("R6 ff without ext mode", 1, 16'h66FF, 0,0,0,0, 4'd9, 2'b11, 4'd6, 8'd0, 32'hFFFFFFFF, 1'b0, 0, 0, 0);
        // R8 moveq
        issue("R8 moveq", 1, 16'h7A85, 0,0,0,0, 4'd10, 2'b10, 4'd0, 8'h85, 32'd0, 1'b0, 0, 0, 0);
        idle(3);
        chk("R13", {31'd0, done}, 32'd0, "done after idle");
        chk("R13", {24'd0, quick}, 32'h85, "held quick");
        chk("R13", {29'd0, rhi}, 32'd5, "held reg_hi");
        issue("R8 moveq bit8 illegal", 1, 16'h7B85, 0,0,0,0, 4'd0, 2'b11, 4'd0, 8'd0, 32'd0, 1'b1, 0, 0, 0);
        // R9 shifts
        issue("R9 shift imm zero means 8", 1, 16'hE181, 0,0,0,0, 4'd11, 2'b10, 4'd0, 8'd8, 32'd0, 1'b0, 0, 0, 0);
        issue("R9 shift by register", 1, 16'hE2A1, 0,0,0,0, 4'd12, 2'b10, 4'd0, 8'd0, 32'd0, 1'b0, 0, 0, 0);
        issue("R9 memory shift", 2, 16'hE1E8, 16'h0008, 0,0,0, 4'd13, 2'b01, 4'd0, 8'd1, 32'd0, 1'b0, 0, 0, 0);
        // R10 status immediates
        issue("R10 ccr imm", 2, 16'h003C, 16'h00FF, 0,0,0, 4'd14, 2'b00, 4'd0, 8'd0, 32'h000000FF, 1'b0, 0, 0, 0);
        issue("R10 sr imm", 2, 16'h0A7C, 16'h8700, 0,0,0, 4'd15, 2'b01, 4'd0, 8'd0, 32'h00008700, 1'b0, 0, 0, 0);
        issue("R10 bad optype illegal", 1, 16'h043C, 0,0,0,0, 4'd0, 2'b11, 4'd0, 8'd0, 32'd0, 1'b1, 0, 0, 0);
        // R11 illegal groups and modes
        issue("R11 group A", 1, 16'hA000, 0,0,0,0, 4'd0, 2'b11, 4'd0, 8'd0, 32'd0, 1'b1, 0, 0, 0);
        issue("R11 group F", 1, 16'hF123, 0,0,0,0, 4'd0, 2'b11, 4'd0, 8'd0, 32'd0, 1'b1, 0, 0, 0);
        issue("R11 bad mode7 reg5", 1, 16'h303D, 0,0,0,0, 4'd0, 2'b11, 4'd0, 8'd0, 32'd0, 1'b1, 0, 0, 0);
        // R14 other groups
        issue("R14 other group 4", 1, 16'h4E71, 0,0,0,0, 4'd0, 2'b01, 4'd0, 8'd0, 32'd0, 1'b0, 0, 0, 0);
        issue("R14 other group D", 1, 16'hD280, 0,0,0,0, 4'd0, 2'b10, 4'd0, 8'd0, 32'd0, 1'b0, 0, 0, 0);
        idle(2);

        // R12 load with no word
        @(negedge clk);
        pc_load = 1'b1;
        pc_val  = 32'h0000_2000;
        @(negedge clk);
        pc_load = 1'b0;
        chk("R12", pc, 32'h0000_2000, "pc after bare load");
        exp_pc = 32'h0000_2000;
        issue("R12 step after load", 1, 16'h3401, 0,0,0,0, 4'd1, 2'b01, 4'd0, 8'd0, 32'd0, 1'b0, 0, 0, 0);
        idle(3);
        chk("R13", {31'd0, done}, 32'd0, "no stray completion");
        chk("R13", {31'd0, 1'(exp_q.size())}, 32'd0, "scoreboard drained");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule